// File: doc/BRIEF.md
# Multi-Lane Double-Data-Rate Serial Sample Source

This block acts as the transmit side of a multi-channel converter with serial outputs, so that a matching deserializer can be driven with known data. Eight parallel 14-bit sample words are accepted together through a valid/ready handshake. Each word leaves on its own one-bit lane, most significant bit first. A forwarded data clock carries one bit per edge, and a frame clock marks where each word begins.

Everything runs on one internal clock at twice the lane bit rate. A frame lasts 28 internal cycles, which is 14 bits of two cycles each. The data clock changes only halfway through a bit, so its edges sit at the centre of the data eye. When no new words arrive, the last words are sent again, so the output clocks never stop. The lanes and both clocks come straight from flip-flops.

Top module: `lane_ddr_tx`

## Requirements
- R1: While `rst_n` is low at a rising edge, every lane, `dclk_out` and `fclk_out` are low from the next cycle on, and `in_ready` is low while `rst_n` is low.
- R2: `in_ready` is high in the first cycle after `rst_n` returns high, and then for exactly one cycle in every 28.
- R3: When `in_valid` and `in_ready` are both high at a rising edge, all eight words are captured together. In the following cycle each lane shows bit 13 of its new word.
- R4: Lane i carries `in_samples[14*i+13 : 14*i]`. Counting output cycles of a frame from 0, cycle c shows word bit 13 - c/2 (integer division), so every bit is held for two cycles, most significant bit first.
- R5: In output cycle c of a frame, `dclk_out` equals bit 1 of c+1. It is low in cycle 0, rises in cycle 1 and has a period of 4 cycles. It never changes on the same edge as a lane.
- R6: `fclk_out` is high for output cycles 0 to 13 of each frame (7 bits) and low for cycles 14 to 27.
- R7: If `in_valid` is low while `in_ready` is high, the frame that follows repeats the last captured words, and both clocks keep running.
- R8: `in_valid` and `in_samples` have no effect in cycles where `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the lane bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample words on `in_samples` are valid |
| in_ready | output | 1 | Frame start; words are taken in this cycle |
| in_samples | input | 112 | Eight 14-bit words, lane i at bits 14*i+13 to 14*i |
| lane_out | output | 8 | Serial data, one bit per lane |
| dclk_out | output | 1 | Forwarded data clock, one bit per edge |
| fclk_out | output | 1 | Frame clock, high for the first half of each word |

## Verification
The checker watches several properties on every cycle:
- reset drives the outputs low;
- `in_ready` is a single-cycle pulse on a 28-cycle grid that starts right after reset;
- the lanes never switch on the same edge as the data clock;
- the frame clock rises only while the data clock is low;
- a handshake puts the new words' top bits on the lanes one cycle later.

Only the bench scenarios show the rest. These are the full bit order across a frame for several data patterns, the exact data-clock and frame-clock waveforms, a frame repeated when no words are offered, and the fact that words offered while `in_ready` is low are ignored.

// File: rtl/lane_ddr_pkg.sv
// Package: shared defaults and helpers for the double-data-rate lane source.
// Assumes: the internal clock runs at twice the lane bit rate (two cycles per bit).
package lane_ddr_pkg;

    parameter int unsigned DEF_LANES  = 8;
    parameter int unsigned DEF_WORD_W = 14;

    // Internal cycles per bit; the data clock toggles between the two halves.
    parameter int unsigned CYC_PER_BIT = 2;

    // Number of internal cycles in one frame of a word of the given width.
    function automatic int unsigned frame_cycles(input int unsigned word_w);
        return word_w * CYC_PER_BIT;
    endfunction

endpackage

// File: rtl/ldt_slot_timer.sv
// Module: ldt_slot_timer
// Counts the internal cycles of a frame. From the count it gives the frame-start
// strobe and the index of the word bit for the next output cycle. It also
// registers the data clock and the frame clock.
// Assumes: WORD_W is even, so the data clock ends each frame at the level it began.
module ldt_slot_timer
    import lane_ddr_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned SLOTS  = frame_cycles(WORD_W),
    parameter int unsigned CNT_W  = $clog2(SLOTS),
    parameter int unsigned IDX_W  = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             frame_start,
    output logic [IDX_W-1:0] bit_idx,
    output logic             dclk_q,
    output logic             fclk_q
);

    logic [CNT_W-1:0] slot_q;
    logic [CNT_W-1:0] half_slot;
    logic [CNT_W:0]   slot_plus1;

    // Purpose: step through the frame slots and wrap at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (slot_q == CNT_W'(SLOTS - 1)) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Purpose: decode the frame start and the word bit for the current slot.
    always_comb begin
        frame_start = (slot_q == '0);
        half_slot   = slot_q >> 1;
        bit_idx     = IDX_W'(WORD_W - 1) - half_slot[IDX_W-1:0];
        slot_plus1  = {1'b0, slot_q} + (CNT_W + 1)'(1);
    end

    // Purpose: register both clocks; the data clock moves only in the middle of a bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk_q <= 1'b0;
            fclk_q <= 1'b0;
        end else begin
            dclk_q <= slot_plus1[1];
            fclk_q <= (slot_q < CNT_W'(WORD_W));
        end
    end

endmodule

// File: rtl/ldt_word_hold.sv
// Module: ldt_word_hold
// Holds the words of all lanes, loading all of them together on a handshake.
// The source words follow the input during a load and the held copy otherwise,
// so the first bit of a frame is taken from fresh data.
// Assumes: load is high only in a frame-start cycle.
module ldt_word_hold
    import lane_ddr_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned BUS_W  = LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] words_in,
    output logic [BUS_W-1:0] words_src
);

    logic [BUS_W-1:0] held_q;

    // Purpose: take a new set of words on a handshake, otherwise keep the old set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= words_in;
        end
    end

    // Purpose: use the incoming words during a load so the first bit has no gap.
    always_comb begin
        words_src = load ? words_in : held_q;
    end

endmodule

// File: rtl/ldt_lane_drive.sv
// Module: ldt_lane_drive
// One serial lane: registers the selected bit of its word so that the pin is
// driven straight from a flip-flop.
// Assumes: bit_idx is in range 0 to WORD_W-1.
module ldt_lane_drive
    import lane_ddr_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              lane_q
);

    // Purpose: register the current word bit onto the lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= 1'b0;
        end else begin
            lane_q <= word[bit_idx];
        end
    end

endmodule

// File: rtl/lane_ddr_tx.sv
// Module: lane_ddr_tx (top)
// Serializes LANES parallel words onto LANES one-bit lanes, most significant bit
// first. It forwards a data clock that carries one bit per edge and a frame clock
// that is high for the first half of each word.
// Assumes: clk runs at twice the lane bit rate; in_ready marks each frame start.
module lane_ddr_tx
    import lane_ddr_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [LANES*WORD_W-1:0]   in_samples,
    output logic [LANES-1:0]          lane_out,
    output logic                      dclk_out,
    output logic                      fclk_out
);

    localparam int unsigned BUS_W = LANES * WORD_W;
    localparam int unsigned IDX_W = $clog2(WORD_W);

    logic             frame_start;
    logic [IDX_W-1:0] bit_idx;
    logic             load;
    logic [BUS_W-1:0] words_src;

    ldt_slot_timer #(.WORD_W(WORD_W)) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .bit_idx     (bit_idx),
        .dclk_q      (dclk_out),
        .fclk_q      (fclk_out)
    );

    // Purpose: offer the handshake only at a frame start and only out of reset.
    always_comb begin
        in_ready = rst_n && frame_start;
        load     = in_valid && in_ready;
    end

    ldt_word_hold #(.LANES(LANES), .WORD_W(WORD_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .words_in  (in_samples),
        .words_src (words_src)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ldt_lane_drive #(.WORD_W(WORD_W)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .word    (words_src[g*WORD_W +: WORD_W]),
            .bit_idx (bit_idx),
            .lane_q  (lane_out[g])
        );
    end

endmodule

// File: rtl/lane_ddr_tx_chk.sv
// Module: lane_ddr_tx_chk
// Checker bound to lane_ddr_tx. It watches the handshake grid, the reset levels,
// the edge placement between lanes and clocks, and the first bit after a load.
module lane_ddr_tx_chk
    import lane_ddr_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [LANES*WORD_W-1:0] in_samples,
    input logic [LANES-1:0]        lane_out,
    input logic                    dclk_out,
    input logic                    fclk_out
);

    localparam int unsigned SLOTS = frame_cycles(WORD_W);
    localparam int unsigned CW    = $clog2(SLOTS);

    logic [CW-1:0]    grid_q;
    logic [LANES-1:0] top_bits;

    // Purpose: independent frame grid counter used to check the ready spacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grid_q <= '0;
        end else if (grid_q == CW'(SLOTS - 1)) begin
            grid_q <= '0;
        end else begin
            grid_q <= grid_q + 1'b1;
        end
    end

    // Purpose: gather the top bit of each incoming word.
    for (genvar g = 0; g < LANES; g++) begin : g_top
        assign top_bits[g] = in_samples[g*WORD_W + WORD_W - 1];
    end

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (lane_out == '0 && !dclk_out && !fclk_out));

    assert_ready_grid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (grid_q == '0));

    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    assert_load_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (lane_out == $past(top_bits)));

    assert_edges_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lane_out) |-> $stable(dclk_out));

    assert_frame_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fclk_out) |-> !dclk_out);

endmodule

bind lane_ddr_tx lane_ddr_tx_chk #(.LANES(LANES), .WORD_W(WORD_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_samples (in_samples),
    .lane_out   (lane_out),
    .dclk_out   (dclk_out),
    .fclk_out   (fclk_out)
);

// File: tb/lane_ddr_tx_tb_top.sv
// Directed bench for lane_ddr_tx. Inputs change on falling edges and outputs are
// sampled on falling edges.
module lane_ddr_tx_tb_top;

    localparam int LANES  = 8;
    localparam int WORD_W = 14;
    localparam int BUS_W  = LANES * WORD_W;
    localparam int SLOTS  = 2 * WORD_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [BUS_W-1:0] in_samples = '0;
    logic [LANES-1:0] lane_out;
    logic             dclk_out;
    logic             fclk_out;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    lane_ddr_tx #(.LANES(LANES), .WORD_W(WORD_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_samples (in_samples),
        .lane_out   (lane_out),
        .dclk_out   (dclk_out),
        .fclk_out   (fclk_out)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] make_words(input int seed);
        logic [BUS_W-1:0] v;
        for (int i = 0; i < LANES; i++) begin
            v[i*WORD_W +: WORD_W] = WORD_W'((seed * (i + 3)) ^ (i * 16'h0915));
        end
        return v;
    endfunction

    // Check one whole frame of output; the call starts on output cycle 0.
    task automatic check_frame(input logic [BUS_W-1:0] w, input string req);
        for (int c = 0; c < SLOTS; c++) begin
            logic [LANES-1:0] exp_l;
            logic [5:0]       cp1;
            for (int i = 0; i < LANES; i++) begin
                exp_l[i] = w[i*WORD_W + WORD_W - 1 - c/2];
            end
            cp1 = 6'(c + 1);
            check({req, " R4 lanes"}, $sformatf("slot %0d", c), 32'(lane_out), 32'(exp_l));
            check("R5 dclk", $sformatf("slot %0d", c), 32'(dclk_out), 32'(cp1[1]));
            check("R6 fclk", $sformatf("slot %0d", c), 32'(fclk_out), 32'(c < WORD_W));
            @(negedge clk);
        end
    endtask

    task automatic wait_ready();
        while (!in_ready) @(negedge clk);
    endtask

    // Offer words at the next frame start and check the frame that carries them.
    task automatic t_send(input logic [BUS_W-1:0] w);
        wait_ready();
        in_samples = w;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
        in_samples = '0;
        check_frame(w, "R3");
    endtask

    // Reset levels, then the ready pulse grid after release.
    task automatic t_reset();
        int bad;
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "lanes in reset", 32'(lane_out), 32'h0);
        check("R1", "dclk in reset", 32'(dclk_out), 32'h0);
        check("R1", "fclk in reset", 32'(fclk_out), 32'h0);
        check("R1", "ready in reset", 32'(in_ready), 32'h0);
        rst_n = 1'b1;
        #1;
        check("R2", "ready first cycle", 32'(in_ready), 32'h1);
        bad = 0;
        for (int k = 1; k < SLOTS; k++) begin
            @(negedge clk);
            if (in_ready) bad++;
        end
        check("R2", "ready high mid-frame count", 32'(bad), 32'h0);
        @(negedge clk);
        check("R2", "ready after 28 cycles", 32'(in_ready), 32'h1);
    endtask

    // No valid at the frame start: the previous words are sent again.
    task automatic t_repeat(input logic [BUS_W-1:0] w);
        t_send(w);
        wait_ready();
        @(negedge clk);
        check_frame(w, "R7");
    endtask

    // Valid words offered while ready is low must not reach the lanes.
    task automatic t_ignore(input logic [BUS_W-1:0] w, input logic [BUS_W-1:0] junk);
        t_send(w);
        in_valid   = 1'b1;
        in_samples = junk;
        for (int k = 0; k < 10; k++) begin
            if (in_ready) begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        in_valid   = 1'b0;
        in_samples = '0;
        wait_ready();
        @(negedge clk);
        check_frame(w, "R8");
    endtask

    // Reset in the middle of a frame forces the outputs low.
    task automatic t_mid_reset(input logic [BUS_W-1:0] w);
        wait_ready();
        in_samples = w;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "lanes after mid reset", 32'(lane_out), 32'h0);
        check("R1", "dclk after mid reset", 32'(dclk_out), 32'h0);
        check("R1", "fclk after mid reset", 32'(fclk_out), 32'h0);
    endtask

    initial begin
        logic [BUS_W-1:0] alt;
        for (int i = 0; i < LANES; i++) alt[i*WORD_W +: WORD_W] = 14'h2AAA;
        @(negedge clk);
        t_reset();
        t_send(make_words(16'h1357));
        t_send(alt);
        t_send({BUS_W{1'b1}});
        t_send({{(BUS_W/2){1'b0}}, {(BUS_W/2){1'b1}}});
        t_repeat(make_words(16'h0BAD));
        t_ignore(make_words(16'h2468), ~make_words(16'h2468));
        t_mid_reset(alt);
        t_reset();
        t_send(make_words(16'h3C1F));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1-all: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule